// File: doc/BRIEF.md
# Scrambled MLT-3 Transmit Serializer

This block is the digital tail of a 100 Mb/s twisted-pair transmitter. Once every five bit clocks it asks for a 5-bit code group and takes it. It then emits the group one bit per clock, least significant bit first. Each bit is XORed with a keystream from an 11-bit linear feedback shift register. The scrambled stream is turned into transitions (NRZI), and each transition moves a three-level MLT-3 line state. The result is a 2-bit signed level code that the analog driver turns into line voltage.

The keystream register takes its starting value from the port's PHY address when reset is applied. Ports with different addresses therefore scramble with different sequences. The register steps on every clock, idle code groups included, so repeated patterns never reach the line unbroken.

Top module: `mlt3_scram_tx`

## Requirements
- R1: While `rst_n` is low at a clock edge (synchronous reset), the block returns to its start state. In the first cycle after release, `line_level` is 0 (2'b00) and `group_load` is high.
- R2: `group_load` is high in the first cycle after reset and then in exactly one cycle out of every five. The code group is taken only in a cycle with `group_load` high; `group_in` in any other cycle has no effect on the output.
- R3: The bits of a taken group are consumed on five consecutive clocks, starting with the edge that takes the group, bit 0 first and bit 4 last.
- R4: The keystream register is 11 bits wide and is reset to {6'b101011, phy_addr}. Each clock, its output bit is state[10] XOR state[8] (polynomial x^11 + x^9 + 1). The state shifts one place toward the MSB, and that output bit enters at bit 0. It steps on every clock after reset, whatever the data.
- R5: A scrambled bit (data bit XOR keystream bit) of 0 leaves `line_level` unchanged.
- R6: A scrambled bit of 1 moves `line_level` one step along the cycle 0, +1, 0, -1, 0, ... The levels are coded as 2'b00 for 0, 2'b01 for +1 and 2'b11 for -1; 2'b10 never appears.
- R7: The change caused by the bit consumed at a clock edge is visible on `line_level` right after that same edge.
- R8: Two different PHY addresses, with the same data sent, give different keystreams.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz bit clock |
| rst_n | input | 1 | Synchronous active-low reset; also loads the keystream seed |
| phy_addr | input | 5 | Port address used to build the keystream seed |
| group_in | input | 5 | Code group, taken when `group_load` is high |
| group_load | output | 1 | High in the cycle in which `group_in` is taken |
| line_level | output | 2 | Signed MLT-3 level: 00 = 0, 01 = +1, 11 = -1 |

## Verification
The hardest property to reach from the ports is that the output depends only on the seeded keystream and the taken groups. That means the bytes that sit on `group_in` between strobes, and the history from before a reset, must leave no trace. The bench sends garbage on `group_in` in every non-strobe cycle of one phase. It then re-applies reset mid-run with a second address. Its reference model turns `line_level` transitions back into scrambled bits, strips its own keystream, and compares the result against a queue of the expected data bits. Sending the all-ones idle group under both addresses exposes the two raw keystreams, which the bench then compares.

// File: rtl/mlt3_pkg.sv
package mlt3_pkg;
  typedef logic signed [1:0] level_t;

  localparam level_t LVL_ZERO = 2'sb00;
  localparam level_t LVL_POS  = 2'sb01;
  localparam level_t LVL_NEG  = 2'sb11;

  // MLT-3 phase 0..3 maps onto 0, +1, 0, -1
  function automatic level_t phase_level(input logic [1:0] ph);
    case (ph)
      2'd1:    phase_level = LVL_POS;
      2'd3:    phase_level = LVL_NEG;
      default: phase_level = LVL_ZERO;
    endcase
  endfunction

  // keystream output bit of a Fibonacci register: top bit XOR the second tap
  function automatic logic key_bit(input logic [10:0] st, input int unsigned tap_lo);
    key_bit = st[10] ^ st[tap_lo - 1];
  endfunction
endpackage

// File: rtl/group_piso.sv
module group_piso #(
  parameter int unsigned GROUP_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [GROUP_W-1:0] group_in,
  output logic               load_o,
  output logic               bit_o
);
  localparam int unsigned CNT_W = (GROUP_W > 1) ? $clog2(GROUP_W) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(GROUP_W - 1);

  logic [CNT_W-1:0]   slot_q;
  logic [GROUP_W-1:0] shreg_q;

  assign load_o = (slot_q == '0);
  // bit 0 of a fresh group goes out in the very cycle it is taken
  assign bit_o  = load_o ? group_in[0] : shreg_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q  <= '0;
      shreg_q <= '0;
    end else begin
      slot_q  <= (slot_q == CNT_LAST) ? '0 : slot_q + 1'b1;
      shreg_q <= load_o ? (group_in >> 1) : (shreg_q >> 1);
    end
  end

  assert_load_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> !load_o);
  assert_slot_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q <= CNT_LAST);
endmodule

// File: rtl/keystream_lfsr.sv
module keystream_lfsr #(
  parameter int unsigned LFSR_W = 11,
  parameter int unsigned TAP_LO = 9,
  parameter int unsigned ADDR_W = 5,
  parameter logic [LFSR_W-ADDR_W-1:0] SEED_HI = 6'b101011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              key_o
);
  import mlt3_pkg::*;

  logic [LFSR_W-1:0] st_q;

  assign key_o = key_bit(st_q, TAP_LO);

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= {SEED_HI, addr};
    else        st_q <= {st_q[LFSR_W-2:0], key_o};
  end

  assert_state_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    st_q != '0);
  assert_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (st_q[LFSR_W-1:1] == $past(st_q[LFSR_W-2:0])));
endmodule

// File: rtl/mlt3_coder.sv
module mlt3_coder (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bit_i,
  output mlt3_pkg::level_t      level_o
);
  import mlt3_pkg::*;

  logic       nrzi_q;
  logic [1:0] phase_q;

  assign level_o = phase_level(phase_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nrzi_q  <= 1'b0;
      phase_q <= 2'd0;
    end else begin
      nrzi_q  <= nrzi_q ^ bit_i;
      phase_q <= phase_q + {1'b0, bit_i};
    end
  end

  assert_hold_on_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_i |=> $stable(level_o));
  assert_move_on_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bit_i |=> !$stable(level_o));
  assert_no_direct_swing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (level_o != LVL_ZERO) |=> (level_o == LVL_ZERO || $stable(level_o)));
  assert_legal_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    level_o != 2'sb10);
  assert_nrzi_tracks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($stable(nrzi_q) == $stable(level_o)));
endmodule

// File: rtl/mlt3_scram_tx.sv
module mlt3_scram_tx #(
  parameter int unsigned GROUP_W = 5,
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned LFSR_W  = 11,
  parameter int unsigned TAP_LO  = 9,
  parameter logic [LFSR_W-ADDR_W-1:0] SEED_HI = 6'b101011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic [GROUP_W-1:0] group_in,
  output logic              group_load,
  output logic [1:0]        line_level
);
  import mlt3_pkg::*;

  logic   data_bit;
  logic   key_bit_w;
  logic   scr_bit;
  level_t level_w;

  group_piso #(.GROUP_W(GROUP_W)) u_piso (
    .clk(clk), .rst_n(rst_n), .group_in(group_in),
    .load_o(group_load), .bit_o(data_bit)
  );

  keystream_lfsr #(.LFSR_W(LFSR_W), .TAP_LO(TAP_LO), .ADDR_W(ADDR_W),
                   .SEED_HI(SEED_HI)) u_key (
    .clk(clk), .rst_n(rst_n), .addr(phy_addr), .key_o(key_bit_w)
  );

  assign scr_bit = data_bit ^ key_bit_w;

  mlt3_coder u_coder (
    .clk(clk), .rst_n(rst_n), .bit_i(scr_bit), .level_o(level_w)
  );

  assign line_level = level_w;

  assert_reset_level_R1: assert property (@(posedge clk)
    !rst_n |=> (line_level == 2'b00 && group_load));
endmodule

// File: tb/test_mlt3_scram_tx.sv
module test_mlt3_scram_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] phy_addr = 5'd0;
  logic [4:0] group_in = 5'd0;
  logic       group_load;
  logic [1:0] line_level;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  mlt3_scram_tx i_mlt3_scram_tx (
    .clk(clk), .rst_n(rst_n), .phy_addr(phy_addr), .group_in(group_in),
    .group_load(group_load), .line_level(line_level)
  );

  // scoreboard and models
  bit xhist[$];     // keystream recurrence history
  bit exp_data[$];  // data bits expected to be consumed, in order
  int ph;           // model MLT-3 phase
  int prev_lvl;
  int cyc;
  bit rec_key_a[60];
  bit rec_key_b[60];

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int lvl_int(input logic [1:0] l);
    return int'($signed(l));
  endfunction

  // R4 as a recurrence: x[n+11] = x[n] ^ x[n+2]; keystream bit n = x[n] ^ x[n+2]
  function automatic bit next_key();
    bit k;
    k = xhist[0] ^ xhist[2];
    void'(xhist.pop_front());
    xhist.push_back(k);
    return k;
  endfunction

  function automatic logic [4:0] gen_group(input int mode, input int idx);
    case (mode)
      0: return 5'h1F;
      1: return 5'(idx * 7 + 3);
      2: return (idx % 2) ? 5'h0A : 5'h15;
      default: return 5'h00;
    endcase
  endfunction

  task automatic do_reset(input logic [4:0] a);
    logic [10:0] seed;
    rst_n = 1'b0;
    phy_addr = a;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    seed = {6'b101011, a};
    xhist.delete();
    for (int j = 0; j < 11; j++) xhist.push_back(seed[10 - j]);
    exp_data.delete();
    ph = 0;
    prev_lvl = 0;
    cyc = 0;
    chk(line_level == 2'b00, "R1 level after reset", lvl_int(line_level), 0);
    chk(group_load == 1'b1, "R1 strobe after reset", group_load, 1);
  endtask

  // record: 0 none, 1 into rec_key_a, 2 into rec_key_b
  task automatic run(input int cycles, input int mode, input bit junk, input int record);
    int gidx = 0;
    for (int c = 0; c < cycles; c++) begin
      // driver
      chk(group_load == ((cyc % 5) == 0), "R2 strobe period", group_load, ((cyc % 5) == 0));
      if (group_load) begin
        logic [4:0] g;
        g = gen_group(mode, gidx);
        gidx++;
        group_in = g;
        for (int b = 0; b < 5; b++) exp_data.push_back(g[b]);  // R3 LSB first
      end else if (junk) begin
        group_in = 5'($urandom);  // R2 must be ignored
      end
      @(posedge clk);
      @(negedge clk);
      cyc++;
      // monitor: decode MLT-3 back to scrambled bit, descramble, compare
      begin
        bit d, k, s_exp, s_obs;
        int lv, exp_lv;
        d = exp_data.pop_front();
        k = next_key();
        s_exp = d ^ k;
        if (s_exp) ph = (ph + 1) % 4;
        exp_lv = (ph == 1) ? 1 : ((ph == 3) ? -1 : 0);
        lv = lvl_int(line_level);
        chk(line_level != 2'b10, "R6 legal level code", lv, exp_lv);
        if (s_exp) chk(lv == exp_lv, "R6 R7 step on one", lv, exp_lv);
        else       chk(lv == exp_lv, "R5 R7 hold on zero", lv, exp_lv);
        s_obs = (lv != prev_lvl);
        chk((s_obs ^ k) == d, junk ? "R2 R3 R4 descrambled data (junk between strobes)"
                                   : "R3 R4 descrambled data", int'(s_obs ^ k), int'(d));
        if (record == 1 && c < 60) rec_key_a[c] = s_obs ^ d;
        if (record == 2 && c < 60) rec_key_b[c] = s_obs ^ d;
        prev_lvl = lv;
      end
    end
  endtask

  initial begin
    do_reset(5'h03);
    run(60, 0, 1'b0, 1);     // idle groups, keystream capture A
    run(200, 1, 1'b0, 0);    // varied groups
    run(200, 2, 1'b1, 0);    // alternating groups, garbage between strobes
    run(100, 3, 1'b0, 0);    // all-zero data: raw keystream on the line
    do_reset(5'h1C);         // mid-run reset with another address
    run(60, 0, 1'b0, 2);     // keystream capture B
    run(150, 1, 1'b1, 0);
    begin
      int diff = 0;
      for (int i = 0; i < 60; i++) if (rec_key_a[i] != rec_key_b[i]) diff++;
      chk(diff > 0, "R8 keystreams differ across addresses", diff, 1);
    end
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, -1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule